// File: doc/BRIEF.md
# Smartcard Character Receiver

This block receives asynchronous characters on the single data line of a contact smartcard. Bit time is not taken from a baud divider on the system clock. The receiver counts rising edges of the card's own clock, so a character stays correctly framed whatever card-clock frequency is in use. Both the data line and the card clock are synchronized into the system clock domain. A falling edge on the idle line starts a character. The receiver then samples ten positions: a start bit, eight data bits sent least significant first, and a parity bit. It presents the byte with a one-cycle strobe and a parity-error flag.

The length of one elementary time unit (etu), counted in card-clock cycles, comes from a pair of 4-bit indices. The first index selects a clock-rate factor and the second selects a baud-rate divisor. The etu is the integer quotient of the two. A new index pair is requested with a load pulse. The request is only applied while no character is in flight, and a pair outside the tables is rejected with a flag. A protocol engine above this block issues the load pulse after a successful speed negotiation and consumes the byte strobe.

Top module: `sc_char_rx`

## Requirements
- R1: After reset the etu is 372 card-clock cycles, no character is in progress (`rx_busy` low), and `rx_valid` and `cfg_bad` are low.
- R2: A high-to-low transition of the data line while idle starts a character. The first sample is taken on the card-clock rising edge numbered floor(etu/3) after the transition. Nine more samples follow, each exactly etu card-clock rising edges after the one before.
- R3: The second sample becomes bit 0 of `rx_data` and the ninth sample becomes bit 7 (least significant bit first).
- R4: `rx_par_err` is high when the eight data samples plus the tenth (parity) sample hold an odd number of ones. The byte is delivered with the flag in either case.
- R5: On an applied load, the clock-rate index maps as 0→372, 1→372, 2→558, 3→744, 4→1116, 5→1488, 6→1860, 9→512, 10→768, 11→1024, 12→1536, 13→2048. The etu becomes that value divided by the baud divisor, with the remainder dropped.
- R6: The baud index maps to the divisor as 0→1, 1→1, 2→2, 3→4, 4→8, 5→16, 6→32, 7→64, 8→12, 9→20.
- R7: If either index is outside its table, `cfg_bad` pulses for one cycle and `etu_cycles` keeps its previous value.
- R8: A load requested during a character leaves `etu_cycles` unchanged until that character is complete. It is applied once the receiver is idle.
- R9: If the first sample reads 1, the character is dropped without a strobe and the receiver returns to idle.
- R10: Each received character raises `rx_valid` for exactly one system-clock cycle. `rx_data` and `rx_par_err` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sc_clk | input | 1 | Card clock, asynchronous to clk |
| sc_io | input | 1 | Card data line, idles high |
| cfg_fi | input | 4 | Clock-rate factor index |
| cfg_di | input | 4 | Baud-rate divisor index |
| cfg_load | input | 1 | Request to apply the index pair |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_par_err | output | 1 | Parity error for the strobed byte |
| rx_busy | output | 1 | A character is in progress |
| cfg_bad | output | 1 | One-cycle pulse: rejected index pair |
| etu_cycles | output | 12 | Current etu in card-clock cycles |

## Verification
The bench keeps the default parameters: a 12-bit etu counter and two synchronizer stages. It runs the card clock at one eighth of the system clock, so each card-clock level is held for four system cycles and both synchronized edges can be seen. With that ratio, index pairs such as 558/64 (etu 8) and 512/12 (etu 42) give short characters. Many data and parity patterns then fit in the run, and a single character at the reset etu of 372 still checks the default timing. A load issued mid-character and a start glitch shorter than a third of an etu exercise the deferral and abort paths.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

    localparam int ETU_W = 12;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RUN  = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic             ok;
        logic [ETU_W-1:0] val;
    } fi_entry_t;

    typedef struct packed {
        logic       ok;
        logic [6:0] val;
    } di_entry_t;

    function automatic fi_entry_t fi_lookup(input logic [3:0] idx);
        fi_entry_t r;
        r.ok = 1'b1;
        case (idx)
            4'd0, 4'd1: r.val = ETU_W'(372);
            4'd2:       r.val = ETU_W'(558);
            4'd3:       r.val = ETU_W'(744);
            4'd4:       r.val = ETU_W'(1116);
            4'd5:       r.val = ETU_W'(1488);
            4'd6:       r.val = ETU_W'(1860);
            4'd9:       r.val = ETU_W'(512);
            4'd10:      r.val = ETU_W'(768);
            4'd11:      r.val = ETU_W'(1024);
            4'd12:      r.val = ETU_W'(1536);
            4'd13:      r.val = ETU_W'(2048);
            default: begin
                r.ok  = 1'b0;
                r.val = '0;
            end
        endcase
        return r;
    endfunction

    function automatic di_entry_t di_lookup(input logic [3:0] idx);
        di_entry_t r;
        r.ok = 1'b1;
        case (idx)
            4'd0, 4'd1: r.val = 7'd1;
            4'd2:       r.val = 7'd2;
            4'd3:       r.val = 7'd4;
            4'd4:       r.val = 7'd8;
            4'd5:       r.val = 7'd16;
            4'd6:       r.val = 7'd32;
            4'd7:       r.val = 7'd64;
            4'd8:       r.val = 7'd12;
            4'd9:       r.val = 7'd20;
            default: begin
                r.ok  = 1'b0;
                r.val = 7'd1;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_in[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_out[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/sc_rx_etu.sv
module sc_rx_etu
    import sc_rx_pkg::*;
#(
    parameter int W = ETU_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [3:0]   fi_idx,
    input  logic [3:0]   di_idx,
    input  logic         busy,
    output logic [W-1:0] etu,
    output logic [W-1:0] third,
    output logic         bad
);
    localparam logic [W-1:0] ETU_RST   = W'(372);
    localparam logic [W-1:0] THIRD_RST = W'(372 / 3);

    typedef struct packed {
        logic         pend;
        logic [3:0]   fi;
        logic [3:0]   di;
        logic [W-1:0] etu;
        logic [W-1:0] third;
        logic         bad;
    } etu_s;

    etu_s q, d;
    fi_entry_t fe;
    di_entry_t de;
    logic [W-1:0] quot;

    always_comb begin
        fe   = fi_lookup(q.fi);
        de   = di_lookup(q.di);
        quot = W'(fe.val) / W'(de.val);
        d     = q;
        d.bad = 1'b0;
        if (load) begin
            d.pend = 1'b1;
            d.fi   = fi_idx;
            d.di   = di_idx;
        end else if (q.pend && !busy) begin
            d.pend = 1'b0;
            if (fe.ok && de.ok) begin
                d.etu   = quot;
                d.third = quot / W'(3);
            end else begin
                d.bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pend  <= 1'b0;
            q.fi    <= '0;
            q.di    <= '0;
            q.etu   <= ETU_RST;
            q.third <= THIRD_RST;
            q.bad   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign etu   = q.etu;
    assign third = q.third;
    assign bad   = q.bad;
endmodule

// File: rtl/sc_rx_core.sv
module sc_rx_core
    import sc_rx_pkg::*;
#(
    parameter int W     = ETU_W,
    parameter int NBITS = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         io_lvl,
    input  logic         ck_lvl,
    input  logic [W-1:0] etu,
    input  logic [W-1:0] third,
    output logic [7:0]   data,
    output logic         valid,
    output logic         perr,
    output logic         busy
);
    localparam int IDX_W = $clog2(NBITS);
    localparam int SH_W  = NBITS - 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBITS - 1);

    typedef struct packed {
        rx_state_e       st;
        logic            io_prev;
        logic            ck_prev;
        logic [W-1:0]    cnt;
        logic [IDX_W-1:0] idx;
        logic [SH_W-1:0] sh;
        logic [7:0]      data;
        logic            valid;
        logic            perr;
    } core_s;

    core_s q, d;
    logic io_fall, ck_rise;
    logic [W-1:0] target;
    logic [SH_W-1:0] sh_nx;

    always_comb begin
        io_fall = q.io_prev & ~io_lvl;
        ck_rise = ~q.ck_prev & ck_lvl;
        target  = (q.idx == '0) ? third : etu;
        sh_nx   = {io_lvl, q.sh[SH_W-1:1]};
        d         = q;
        d.io_prev = io_lvl;
        d.ck_prev = ck_lvl;
        d.valid   = 1'b0;
        case (q.st)
            RX_IDLE: begin
                if (io_fall) begin
                    d.st  = RX_RUN;
                    d.cnt = '0;
                    d.idx = '0;
                end
            end
            default: begin
                if (ck_rise) begin
                    if (q.cnt + W'(1) == target) begin
                        d.cnt = '0;
                        if (q.idx == '0) begin
                            if (io_lvl) d.st  = RX_IDLE;
                            else        d.idx = IDX_W'(1);
                        end else begin
                            d.sh = sh_nx;
                            if (q.idx == LAST) begin
                                d.st    = RX_IDLE;
                                d.valid = 1'b1;
                                d.data  = sh_nx[7:0];
                                d.perr  = ^sh_nx;
                            end else begin
                                d.idx = q.idx + IDX_W'(1);
                            end
                        end
                    end else begin
                        d.cnt = q.cnt + W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= RX_IDLE;
            q.io_prev <= 1'b1;
            q.ck_prev <= 1'b1;
            q.cnt     <= '0;
            q.idx     <= '0;
            q.sh      <= '0;
            q.data    <= '0;
            q.valid   <= 1'b0;
            q.perr    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign data  = q.data;
    assign valid = q.valid;
    assign perr  = q.perr;
    assign busy  = (q.st == RX_RUN);
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
    import sc_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sc_clk,
    input  logic             sc_io,
    input  logic [3:0]       cfg_fi,
    input  logic [3:0]       cfg_di,
    input  logic             cfg_load,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_par_err,
    output logic             rx_busy,
    output logic             cfg_bad,
    output logic [ETU_W-1:0] etu_cycles
);
    logic [1:0]       lvl;
    logic [ETU_W-1:0] third;

    sc_rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sc_clk, sc_io}),
        .sync_out (lvl)
    );

    sc_rx_etu #(.W(ETU_W)) u_etu (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_load),
        .fi_idx (cfg_fi),
        .di_idx (cfg_di),
        .busy   (rx_busy),
        .etu    (etu_cycles),
        .third  (third),
        .bad    (cfg_bad)
    );

    sc_rx_core #(.W(ETU_W), .NBITS(10)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .io_lvl (lvl[0]),
        .ck_lvl (lvl[1]),
        .etu    (etu_cycles),
        .third  (third),
        .data   (rx_data),
        .valid  (rx_valid),
        .perr   (rx_par_err),
        .busy   (rx_busy)
    );
endmodule

// File: rtl/sc_rx_chk.sv
module sc_rx_chk
    import sc_rx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_busy,
    input logic             cfg_bad,
    input logic [ETU_W-1:0] etu_cycles
);
    AST_ETU_HELD_IN_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_busy && $past(rx_busy)) |-> $stable(etu_cycles)); // R8

    AST_BAD_KEEPS_ETU: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |-> $stable(etu_cycles)); // R7

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R10

    AST_VALID_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(rx_busy) && !rx_busy)); // R2

    AST_ETU_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        etu_cycles >= ETU_W'(5)); // R5
endmodule

bind sc_char_rx sc_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_busy    (rx_busy),
    .cfg_bad    (cfg_bad),
    .etu_cycles (etu_cycles)
);

// File: tb/tb_sc_char_rx.sv
module tb_sc_char_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sc_clk = 1'b0;
    logic        sc_io = 1'b1;
    logic [3:0]  cfg_fi = '0;
    logic [3:0]  cfg_di = '0;
    logic        cfg_load = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_par_err;
    logic        rx_busy;
    logic        cfg_bad;
    logic [11:0] etu_cycles;

    int total = 0;
    int bad = 0;
    int cap_n = 0;
    int bad_n = 0;
    logic [7:0] cap_data = '0;
    logic       cap_perr = 1'b0;

    sc_char_rx dut (
        .clk(clk), .rst_n(rst_n), .sc_clk(sc_clk), .sc_io(sc_io),
        .cfg_fi(cfg_fi), .cfg_di(cfg_di), .cfg_load(cfg_load),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
        .rx_busy(rx_busy), .cfg_bad(cfg_bad), .etu_cycles(etu_cycles)
    );

    always #4 clk = ~clk;
    always #32 sc_clk = ~sc_clk;

    always @(negedge clk) begin
        if (rx_valid) begin
            cap_n    <= cap_n + 1;
            cap_data <= rx_data;
            cap_perr <= rx_par_err;
        end
        if (cfg_bad) bad_n <= bad_n + 1;
    end

    // {fi, di, data, parity flip, expected etu}
    localparam logic [28:0] VEC [0:5] = '{
        {4'd9,  4'd8, 8'hA5, 1'b0, 12'd42},
        {4'd13, 4'd9, 8'hE1, 1'b1, 12'd102},
        {4'd2,  4'd7, 8'h00, 1'b0, 12'd8},
        {4'd6,  4'd6, 8'hFF, 1'b1, 12'd58},
        {4'd11, 4'd5, 8'h5C, 1'b0, 12'd64},
        {4'd4,  4'd4, 8'h81, 1'b1, 12'd139}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [3:0] fi, input logic [3:0] di);
        @(negedge clk);
        cfg_fi = fi;
        cfg_di = di;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] b, input logic flip, input int etu);
        logic [9:0] frame;
        frame = {(^b) ^ flip, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge sc_clk);
            sc_io = frame[i];
            repeat (etu - 1) @(negedge sc_clk);
        end
        @(negedge sc_clk);
        sc_io = 1'b1;
        repeat (etu + 2) @(negedge sc_clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 etu", etu_cycles, 372);
        check("R1 busy", rx_busy, 0);
        check("R1 valid", rx_valid, 0);
        check("R1 bad", cfg_bad, 0);

        // R2 default etu character
        n0 = cap_n;
        send_char(8'h3B, 1'b0, 372);
        check("R2 count at 372", cap_n, n0 + 1);
        check("R3 data at 372", cap_data, 8'h3B);

        // table walk: R5 R6 R2 R3 R4 R10
        for (int k = 0; k < 6; k++) begin
            load_cfg(VEC[k][28:25], VEC[k][24:21]);
            check("R5 R6 etu from indices", etu_cycles, VEC[k][11:0]);
            n0 = cap_n;
            send_char(VEC[k][20:13], VEC[k][12], int'(VEC[k][11:0]));
            check("R10 one strobe", cap_n, n0 + 1);
            check("R3 byte lsb first", cap_data, VEC[k][20:13]);
            check("R4 parity flag", cap_perr, VEC[k][12]);
        end

        // R7 invalid indices
        load_cfg(4'd9, 4'd8);
        n0 = bad_n;
        load_cfg(4'd7, 4'd1);
        check("R7 bad fi pulse", bad_n, n0 + 1);
        check("R7 etu kept fi", etu_cycles, 42);
        load_cfg(4'd1, 4'd10);
        check("R7 bad di pulse", bad_n, n0 + 2);
        check("R7 etu kept di", etu_cycles, 42);

        // R8 load during a character
        n0 = cap_n;
        fork
            send_char(8'h6D, 1'b0, 42);
            begin
                repeat (3 * 42) @(negedge sc_clk);
                load_cfg(4'd9, 4'd9);
                check("R8 busy mid char", rx_busy, 1);
                check("R8 etu held mid char", etu_cycles, 42);
            end
        join
        check("R8 char at old etu", cap_data, 8'h6D);
        check("R8 count", cap_n, n0 + 1);
        check("R8 etu applied after", etu_cycles, 25);

        // R9 short start glitch (third = 8)
        n0 = cap_n;
        @(negedge sc_clk);
        sc_io = 1'b0;
        repeat (2) @(negedge sc_clk);
        sc_io = 1'b1;
        repeat (12 * 25) @(negedge sc_clk);
        check("R9 no strobe on glitch", cap_n, n0);
        check("R9 back to idle", rx_busy, 0);
        send_char(8'hC3, 1'b1, 25);
        check("R9 next char data", cap_data, 8'hC3);
        check("R4 parity after glitch", cap_perr, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule